// File: doc/BRIEF.md
# Cycle-prescaled IRQ up-counter

This block is the interrupt timer of a cartridge bank controller. A write port on the CPU bus lets software load an 8-bit reload value four bits at a time, and write a two-bit control value that arms the timer, picks one-shot or repeating operation and clears a pending interrupt. Once armed, a 7-bit prescaler counts CPU-cycle ticks. Every 114 ticks, which is roughly one video scanline, the prescaler advances an 8-bit counter by one.

When the counter is stepped while it holds 0xFF, it takes the reload value again and the interrupt output goes high. At that same step the run bit of the control value is replaced by the repeat bit. A one-shot timer therefore stops, and a repeating timer keeps counting. The interrupt output is a level. It stays high until software writes the control value again or the block is reset.

Writes are decoded on address bits [15:12] and [3:2] only. The other address bits are ignored, so every register appears at many mirrored addresses.

Top module: `irq_scan_timer`

## Requirements
- R1: A write whose address has bits [15:12] = 0xF and bits [3:2] = 0 stores wr_data[3:0] into reload bits [3:0]. With bits [3:2] = 1 it stores wr_data[3:0] into reload bits [7:4]. Address bits [11:4] and [1:0] are ignored.
- R2: A write whose address has bits [15:12] = 0xF and bits [3:2] = 2 is a control write. It stores wr_data[1:0] as the control value, where bit 1 is run and bit 0 is repeat. Writes with any other value in address bits [15:12] change nothing.
- R3: A control write with wr_data[1] = 1 loads the counter from the reload value and clears the prescaler to 0.
- R4: A control write drives irq low on the next cycle, whatever its data. A tick in the same cycle as a control write has no effect.
- R5: A tick advances the prescaler only while run = 1. On the 114th tick after the prescaler was cleared, the prescaler wraps to 0 and steps the counter once. Ticks while run = 0 change neither the prescaler nor the counter.
- R6: A counter step from 0xFF reloads the counter from the reload value and fires. Any other step adds one. After arming with reload value L, irq rises on the 114*(256-L)th tick.
- R7: When the counter fires, run and repeat both take the previous value of repeat.
- R8: After reset the reload value, control value, counter and prescaler are 0, and irq is low.
- R9: irq goes high on the cycle after the counter fires. It stays high until a control write or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_tick | input | 1 | One-cycle pulse per CPU cycle |
| irq | output | 1 | Active-high interrupt level |

## Verification
The firing time is measured in ticks for several reload values. Reload 0xFE gives two steps, 0xFF gives one step and 0x00 gives a full 256-step run, so off-by-one errors at the overflow compare and at the 114-tick wrap produce distinct tick counts. The same measurement is repeated with a tick only on every other cycle, which separates counting ticks from counting clock cycles. It is also repeated after re-arming in the middle of a prescale period, which shows whether arming clears the prescaler. A behavioural model is compared with irq on every cycle. It is driven through mirrored addresses, off-region writes, an acknowledge that coincides with a tick, and a stopped timer receiving ticks; these show whether decoding, acknowledge priority and the run gate are correct.

// File: rtl/scan_timer_pkg.sv
package scan_timer_pkg;

  // Control value layout: bit 1 = run, bit 0 = repeat.
  typedef struct packed {
    logic run;
    logic rpt;
  } tmr_ctrl_t;

  // Control value after the counter fires: both bits copy repeat.
  function automatic tmr_ctrl_t ctrl_after_fire(input tmr_ctrl_t c);
    tmr_ctrl_t n;
    n.run = c.rpt;
    n.rpt = c.rpt;
    return n;
  endfunction

endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import scan_timer_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 8,
  parameter int REGION_W  = 4,
  parameter int REGION_ID = 15,
  parameter int SLOT_LSB  = 2,
  parameter int SLOT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]       wr_nib,
  input  logic [1:0]       wr_ctl,
  input  logic             cnt_fire,
  output logic [CNT_W-1:0] latch_q,
  output tmr_ctrl_t        ctrl_q,
  output logic             ctrl_wr,
  output logic             arm_load
);
  localparam int NIBBLES = CNT_W / 4;
  localparam logic [SLOT_W-1:0] CTRL_SLOT = SLOT_W'(NIBBLES);

  logic              region_hit;
  logic [SLOT_W-1:0] slot;

  assign region_hit = wr_en && (wr_addr[ADDR_W-1 -: REGION_W] == REGION_W'(REGION_ID));
  assign slot       = wr_addr[SLOT_LSB +: SLOT_W];
  assign ctrl_wr    = region_hit && (slot == CTRL_SLOT);
  assign arm_load   = ctrl_wr && wr_ctl[1];

  for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
    always_ff @(posedge clk) begin
      if (!rst_n)
        latch_q[4*k +: 4] <= '0;
      else if (region_hit && (slot == SLOT_W'(k)))
        latch_q[4*k +: 4] <= wr_nib;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (ctrl_wr)
      ctrl_q <= tmr_ctrl_t'(wr_ctl);
    else if (cnt_fire)
      ctrl_q <= ctrl_after_fire(ctrl_q);
  end

endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W      = 7,
  parameter int PRE_PERIOD = 114
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [PRE_W-1:0] pre_q,
  output logic             pre_step
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_PERIOD - 1);

  function automatic logic [PRE_W-1:0] pre_next(input logic [PRE_W-1:0] v);
    return (v == PRE_LAST) ? '0 : v + 1'b1;
  endfunction

  assign pre_step = advance && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)
      pre_q <= '0;
    else if (clear)
      pre_q <= '0;
    else if (advance)
      pre_q <= pre_next(pre_q);
  end

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             fire
);
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] v,
                                                input logic [CNT_W-1:0] r);
    return (&v) ? r : v + 1'b1;
  endfunction

  assign fire = step && (&cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= reload;
    else if (step)
      cnt_q <= cnt_next(cnt_q, reload);
  end

endmodule

// File: rtl/irq_scan_timer.sv
module irq_scan_timer
  import scan_timer_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 7,
  parameter int PRE_PERIOD = 114
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_tick,
  output logic              irq
);
  logic [CNT_W-1:0] latch_q;
  tmr_ctrl_t        ctrl_q;
  logic             ctrl_wr;
  logic             arm_load;
  logic [PRE_W-1:0] pre_q;
  logic             pre_step;
  logic             pre_adv;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_fire;
  logic             unused_data;

  assign unused_data = ^wr_data[DATA_W-1:4];

  timer_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_nib   (wr_data[3:0]),
    .wr_ctl   (wr_data[1:0]),
    .cnt_fire (cnt_fire),
    .latch_q  (latch_q),
    .ctrl_q   (ctrl_q),
    .ctrl_wr  (ctrl_wr),
    .arm_load (arm_load)
  );

  // A control write owns its cycle: ticks then are dropped.
  assign pre_adv = cpu_tick && ctrl_q.run && !ctrl_wr;

  timer_prescaler #(
    .PRE_W      (PRE_W),
    .PRE_PERIOD (PRE_PERIOD)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (arm_load),
    .advance  (pre_adv),
    .pre_q    (pre_q),
    .pre_step (pre_step)
  );

  timer_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (arm_load),
    .step   (pre_step),
    .reload (latch_q),
    .cnt_q  (cnt_q),
    .fire   (cnt_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq <= 1'b0;
    else if (ctrl_wr)
      irq <= 1'b0;
    else if (cnt_fire)
      irq <= 1'b1;
  end

endmodule

// File: rtl/irq_scan_timer_sva.sv
module irq_scan_timer_sva #(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 7,
  parameter int PRE_PERIOD = 114
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             ctrl_wr,
  input logic             arm_load,
  input logic             pre_step,
  input logic             cnt_fire,
  input logic [CNT_W-1:0] latch_q,
  input logic [1:0]       ctrl_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PRE_W-1:0] pre_q
);
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !irq);

  p_fire_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && !ctrl_wr) |=> irq);

  p_irq_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !cnt_fire) |=> !irq);

  p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q < PRE_W'(PRE_PERIOD));

  p_step_wraps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_step |=> (pre_q == '0));

  p_idle_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[1] && !ctrl_wr) |=> ($stable(cnt_q) && $stable(pre_q)));

  p_arm_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm_load |=> ((cnt_q == $past(latch_q)) && (pre_q == '0)));

  p_fire_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fire |=> (cnt_q == $past(latch_q)));

  p_step_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_step && !cnt_fire) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_ctrl_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fire && !ctrl_wr) |=> (ctrl_q == {2{$past(ctrl_q[0])}}));

endmodule

bind irq_scan_timer irq_scan_timer_sva #(
  .CNT_W      (CNT_W),
  .PRE_W      (PRE_W),
  .PRE_PERIOD (PRE_PERIOD)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .ctrl_wr  (ctrl_wr),
  .arm_load (arm_load),
  .pre_step (pre_step),
  .cnt_fire (cnt_fire),
  .latch_q  (latch_q),
  .ctrl_q   (ctrl_q),
  .cnt_q    (cnt_q),
  .pre_q    (pre_q)
);

// File: tb/tb_irq_scan_timer.sv
`timescale 1ns/1ps
module tb_irq_scan_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        cpu_tick = 1'b0;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // behavioural reference state
  int m_latch, m_ctrl, m_cnt, m_pre;
  bit m_irq;

  always #2.5 clk = ~clk;

  irq_scan_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_tick(cpu_tick), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(input bit rst, input bit we, input int a,
                            input int d, input bit tk);
    bit in_reg;
    int slot;
    bit fire;
    if (rst) begin
      m_latch = 0; m_ctrl = 0; m_cnt = 0; m_pre = 0; m_irq = 0;
      return;
    end
    in_reg = we && (((a >> 12) & 15) == 15);
    slot   = (a >> 2) & 3;
    fire   = 0;
    if (in_reg && slot == 2) begin
      m_ctrl = d % 4;
      if (m_ctrl >= 2) begin
        m_cnt = m_latch;
        m_pre = 0;
      end
      m_irq = 0;
    end else if (tk && m_ctrl >= 2) begin
      m_pre = m_pre + 1;
      if (m_pre >= 114) begin
        m_pre = m_pre - 114;
        if (m_cnt == 255) begin
          m_cnt = m_latch;
          fire = 1;
        end else begin
          m_cnt = m_cnt + 1;
        end
      end
    end
    if (fire) begin
      m_irq = 1;
      m_ctrl = (m_ctrl % 2) * 3;
    end
    if (in_reg && slot == 0) m_latch = (m_latch / 16) * 16 + (d % 16);
    if (in_reg && slot == 1) m_latch = (m_latch % 16) + (d % 16) * 16;
  endtask

  task automatic cyc(input bit we, input logic [15:0] a, input logic [7:0] d,
                     input bit tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; cpu_tick = tk;
    @(posedge clk);
    model_step(!rst_n, we, int'(a), int'(d), tk);
    #1;
    check(irq == m_irq, "R9", "irq vs reference model", int'(irq), int'(m_irq));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000, 8'h00, 1'b1);
  endtask

  task automatic set_reload(input int v);
    wr(16'hF000, 8'(v % 16));
    wr(16'hF004, 8'(v / 16));
  endtask

  // arm with ctrl value c, then count ticks until irq rises
  task automatic measure(input int c, input int gap, output int n);
    n = 0;
    wr(16'hF008, 8'(c));
    while (!irq && n < 40000) begin
      for (int g = 0; g < gap; g++) cyc(1'b0, 16'h0000, 8'h00, 1'b0);
      cyc(1'b0, 16'h0000, 8'h00, 1'b1);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    repeat (3) cyc(1'b0, 16'h0000, 8'h00, 1'b1);
    rst_n = 1'b1;
    check(irq == 1'b0, "R8", "irq after reset", int'(irq), 0);
    ticks(300);
    check(irq == 1'b0, "R8", "irq with reset control value", int'(irq), 0);

    // R1: nibble writes via mirrored addresses, upper data bits dropped
    wr(16'hF0F1, 8'h3E);
    wr(16'hFAB4, 8'hAF);
    measure(2, 0, n);
    check(n == 228, "R1", "ticks to fire, reload 0xFE via mirrors", n, 228);

    ticks(300);
    check(irq == 1'b1, "R9", "irq held after fire", int'(irq), 1);

    // R2: writes outside the register region change nothing
    wr(16'h7008, 8'h00);
    wr(16'hE008, 8'h00);
    check(irq == 1'b1, "R2", "off-region control write ignored", int'(irq), 1);

    // R4: acknowledge with a coincident tick
    cyc(1'b1, 16'hF008, 8'h00, 1'b1);
    check(irq == 1'b0, "R4", "irq after acknowledge", int'(irq), 0);
    ticks(500);
    check(irq == 1'b0, "R5", "no count while stopped", int'(irq), 0);

    // R3: re-arm mid-period clears prescaler
    wr(16'hF008, 8'h02);
    ticks(100);
    measure(2, 0, n);
    check(n == 228, "R3", "ticks to fire after re-arm", n, 228);

    // R5: ticks, not clock cycles, are counted
    wr(16'hF008, 8'h00);
    measure(2, 1, n);
    check(n == 228, "R5", "ticks to fire with sparse ticks", n, 228);

    // R2: control write without run stops counting
    wr(16'hF008, 8'h02);
    ticks(200);
    wr(16'hF008, 8'h01);
    ticks(1000);
    check(irq == 1'b0, "R2", "run=0 control write halts timer", int'(irq), 0);

    // R6/R7: single-step reload in repeat mode
    set_reload(255);
    measure(3, 0, n);
    check(n == 114, "R6", "ticks to fire, reload 0xFF", n, 114);
    ticks(50);
    check(irq == 1'b1, "R7", "irq held while repeating", int'(irq), 1);
    wr(16'hF008, 8'h00);
    check(irq == 1'b0, "R4", "acknowledge after repeat fire", int'(irq), 0);

    // R6: full-range count
    set_reload(0);
    measure(2, 0, n);
    check(n == 29184, "R6", "ticks to fire, reload 0x00", n, 29184);

    // R8: reset clears a pending irq
    rst_n = 1'b0;
    cyc(1'b0, 16'h0000, 8'h00, 1'b0);
    rst_n = 1'b1;
    check(irq == 1'b0, "R8", "irq cleared by reset", int'(irq), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5ns * 190000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule